// File: doc/BRIEF.md
# Camera-Side Serial Command and Image Link Endpoint

This block is the peripheral end of a slow four-wire serial link between a host processor and a camera. The host drives an active-low select, a bit clock running at half the system clock, and a receive line into the block. The block drives a transmit line back. All four wires are treated as synchronous to the block's system clock. Edges of the bit clock are found by comparing its present value with its value one clock earlier.

Every word on either line is nine bits long. A one-bit prefix comes first, then eight payload bits, most significant first. On receive, the prefix says whether the payload is a command (0) or something the camera must not act on (1). Only commands are passed to the register logic behind the block. On transmit, the prefix marks the last byte of an image frame. Between frames, the block can get the host's attention by pulling its transmit line low for a few clocks. The host then reacts to the falling edge.

Image bytes come from the capture logic through a valid/take pair. One word is taken per transmitted byte. An interrupt request is a single-clock pulse. It is honoured only when no frame is open and no word is being shifted.

Top module: `camlink_endpoint`

## Requirements
- R1: While `sel_n` is 1, the receive line is ignored and the receive bit count returns to zero, so a partly received word is dropped; the next word after reselection starts with its prefix bit.
- R2: With `sel_n` at 0, the block samples `rx_line` at each rising `bclk` edge. The first bit is the prefix, and the next eight bits are the payload, MSB first. If the prefix is 0, `cmd_valid` pulses high for exactly one clock, in the clock after the ninth rising edge, with the payload on `cmd_byte`.
- R3: A word whose prefix is 1 produces no `cmd_valid` pulse and leaves `cmd_byte` unchanged.
- R4: With `sel_n` at 0, each word is sent on `tx_line` one bit per falling `bclk` edge: the prefix first, then the payload MSB first. The line changes in the clock after the falling edge is seen and holds until the next falling edge.
- R5: The transmitted prefix equals `img_last` of that byte. A byte is loaded on a falling edge while `img_valid` is 1, and `img_take` pulses for one clock in the clock after the load. Words follow each other back to back, with no idle bit between them.
- R6: `tx_line` is 1 after reset and whenever no word is being shifted and no interrupt pulse is in progress.
- R7: A one-clock `irq_req` while no frame is open and no word is shifting drives `tx_line` low for exactly IRQ_LEN clocks, starting the clock after the request; then the line returns high.
- R8: A frame is open from the load of its first byte until a byte with `img_last` = 1 has been fully shifted. Any `irq_req` during that time leaves `tx_line` unchanged.
- R9: Raising `sel_n` in the middle of a transmitted word aborts that word: `tx_line` is 1 in the following clock, and the next word sent starts with its prefix bit.
- R10: `bclk` toggling while `sel_n` is 1 changes neither the receive nor the transmit state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Link select from host, active low |
| bclk | input | 1 | Bit clock from host, half the system clock rate |
| rx_line | input | 1 | Serial data from host |
| cmd_valid | output | 1 | One-clock strobe for a received command byte |
| cmd_byte | output | DATA_W | Payload of the last command received |
| img_valid | input | 1 | An image byte is offered for sending |
| img_byte | input | DATA_W | Image byte to send |
| img_last | input | 1 | The offered byte ends its frame |
| img_take | output | 1 | One-clock strobe: offered byte was loaded |
| irq_req | input | 1 | One-clock request for an attention pulse |
| tx_line | output | 1 | Serial data to host; idles high |

## Verification
The bench builds the block with 8-bit payloads and IRQ_LEN set to 3. With that length, the attention pulse spans several clocks, so an off-by-one in its duration shows up as a changed sample instead of disappearing into a single clock. The receive path is compared against a behavioural model on every clock across a mix of command words, non-command words, a word cut short by deselection, and bit-clock activity while deselected. The transmit path is checked in three situations: back-to-back frames, interrupt requests made both inside and outside an open frame, and a word aborted mid-shift and then restarted.

// File: rtl/camlink_pkg.sv
package camlink_pkg;

  // Bit-clock edge strobes, each valid for one system clock
  typedef struct packed {
    logic rise;
    logic fall;
  } bclk_edge_t;

  // Transmit side activity
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_IRQ   = 2'd2
  } tx_mode_t;

endpackage

// File: rtl/camlink_edge.sv
module camlink_edge
  import camlink_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk,
  output bclk_edge_t edge_o
);

  logic bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk;
  end

  always_comb begin
    edge_o.rise = bclk & ~bclk_q;
    edge_o.fall = ~bclk & bclk_q;
  end

endmodule

// File: rtl/camlink_rx.sv
module camlink_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rise,
  input  logic              rx_line,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_byte
);

  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  // Prefix plus payload, prefix in the top bit
  function automatic logic [WORD_W-1:0] join_word(input logic [WORD_W-2:0] head,
                                                  input logic bit_in);
    return {head, bit_in};
  endfunction

  function automatic logic is_command(input logic [WORD_W-1:0] w);
    return ~w[WORD_W-1];
  endfunction

  logic [WORD_W-2:0] head_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic              last_bit;   // this rising edge completes a word
  logic [WORD_W-1:0] full_word;

  assign last_bit  = rise && (bit_cnt == CNT_W'(WORD_W - 1));
  assign full_word = join_word(head_q, rx_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q    <= '0;
      bit_cnt   <= '0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (sel_n) begin
        bit_cnt <= '0;
      end else if (last_bit) begin
        bit_cnt <= '0;
        if (is_command(full_word)) begin
          cmd_valid <= 1'b1;
          cmd_byte  <= full_word[DATA_W-1:0];
        end
      end else if (rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        head_q  <= full_word[WORD_W-2:0];
      end
    end
  end

  // R1: deselection clears any partial word
  p_desel_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (bit_cnt == '0));

  // R2: a command strobe lasts one clock
  p_cmd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/camlink_tx.sv
module camlink_tx
  import camlink_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IRQ_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              fall,
  input  logic              img_valid,
  input  logic [DATA_W-1:0] img_byte,
  input  logic              img_last,
  input  logic              irq_req,
  output logic              img_take,
  output logic              tx_line
);

  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int IRQ_W  = $clog2(IRQ_LEN + 1);

  function automatic logic [WORD_W-1:0] pack_word(input logic last,
                                                  input logic [DATA_W-1:0] b);
    return {last, b};
  endfunction

  tx_mode_t          mode;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_idx;
  logic [IRQ_W-1:0]  irq_left;
  logic              cur_last;
  logic              frame_open;
  logic              load_ok;    // a byte can be loaded at this edge
  logic              word_end;   // falling edge after the final bit

  assign load_ok  = fall && !sel_n && img_valid;
  assign word_end = (mode == TX_SHIFT) && fall && (bit_idx == CNT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= TX_IDLE;
      shreg      <= '0;
      bit_idx    <= '0;
      irq_left   <= '0;
      cur_last   <= 1'b0;
      frame_open <= 1'b0;
      img_take   <= 1'b0;
    end else begin
      img_take <= 1'b0;
      if (sel_n && mode == TX_SHIFT) begin
        mode    <= TX_IDLE;
        bit_idx <= '0;
      end else begin
        case (mode)
          TX_IDLE: begin
            if (irq_req && !frame_open) begin
              mode     <= TX_IRQ;
              irq_left <= IRQ_W'(IRQ_LEN - 1);
            end else if (load_ok) begin
              mode       <= TX_SHIFT;
              shreg      <= pack_word(img_last, img_byte);
              bit_idx    <= '0;
              cur_last   <= img_last;
              frame_open <= 1'b1;
              img_take   <= 1'b1;
            end
          end
          TX_SHIFT: begin
            if (word_end) begin
              if (cur_last) frame_open <= 1'b0;
              if (load_ok) begin
                shreg      <= pack_word(img_last, img_byte);
                bit_idx    <= '0;
                cur_last   <= img_last;
                frame_open <= 1'b1;
                img_take   <= 1'b1;
              end else begin
                mode <= TX_IDLE;
              end
            end else if (fall) begin
              shreg   <= shreg << 1;
              bit_idx <= bit_idx + 1'b1;
            end
          end
          TX_IRQ: begin
            if (irq_left == '0) mode <= TX_IDLE;
            else                irq_left <= irq_left - 1'b1;
          end
          default: mode <= TX_IDLE;
        endcase
      end
    end
  end

  assign tx_line = (mode == TX_SHIFT) ? shreg[WORD_W-1] : (mode != TX_IRQ);

  // R9: deselection during a word returns to idle
  p_abort_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && mode == TX_SHIFT) |=> (mode == TX_IDLE));

  // R8: an attention pulse never overlaps an open frame
  p_irq_outside_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TX_IRQ) |-> !frame_open);

  // R5: the take strobe lasts one clock
  p_take_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    img_take |=> !img_take);

endmodule

// File: rtl/camlink_endpoint.sv
module camlink_endpoint
  import camlink_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IRQ_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              bclk,
  input  logic              rx_line,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_byte,
  input  logic              img_valid,
  input  logic [DATA_W-1:0] img_byte,
  input  logic              img_last,
  output logic              img_take,
  input  logic              irq_req,
  output logic              tx_line
);

  bclk_edge_t bedge;

  camlink_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .bclk   (bclk),
    .edge_o (bedge)
  );

  camlink_rx #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .rise      (bedge.rise),
    .rx_line   (rx_line),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte)
  );

  camlink_tx #(.DATA_W(DATA_W), .IRQ_LEN(IRQ_LEN)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .fall      (bedge.fall),
    .img_valid (img_valid),
    .img_byte  (img_byte),
    .img_last  (img_last),
    .irq_req   (irq_req),
    .img_take  (img_take),
    .tx_line   (tx_line)
  );

endmodule

// File: tb/sim_camlink_endpoint.sv
module sim_camlink_endpoint;

  localparam int DW  = 8;
  localparam int IRQ = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic bclk = 1'b0;
  logic rx_line = 1'b1;
  logic cmd_valid;
  logic [DW-1:0] cmd_byte;
  logic img_valid = 1'b0;
  logic [DW-1:0] img_byte = '0;
  logic img_last = 1'b0;
  logic img_take;
  logic irq_req = 1'b0;
  logic tx_line;

  int checks = 0;
  int errors = 0;
  int cmd_seen = 0;
  logic [DW:0] img_q[$];

  always #2 clk = ~clk;

  camlink_endpoint #(.DATA_W(DW), .IRQ_LEN(IRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .bclk(bclk), .rx_line(rx_line),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .img_valid(img_valid), .img_byte(img_byte), .img_last(img_last),
    .img_take(img_take), .irq_req(irq_req), .tx_line(tx_line)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural receive model, stepped on each rising clock
  int m_cnt = 0;
  bit m_prev = 0;
  logic [DW:0] m_word = '0;
  bit exp_v = 0;
  logic [DW-1:0] exp_b = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prev = 0; exp_v = 0;
    end else begin
      exp_v = 0;
      if (sel_n) m_cnt = 0;
      else if (bclk && !m_prev) begin
        m_word = {m_word[DW-1:0], rx_line};
        m_cnt++;
        if (m_cnt == DW + 1) begin
          m_cnt = 0;
          if (!m_word[DW]) begin exp_v = 1; exp_b = m_word[DW-1:0]; end
        end
      end
      m_prev = bclk;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cmd_valid == exp_v, "R2 R3 strobe per clock", int'(cmd_valid), int'(exp_v));
      if (exp_v) chk(cmd_byte == exp_b, "R2 payload", int'(cmd_byte), int'(exp_b));
      if (cmd_valid) cmd_seen++;
      if (img_take && img_q.size() > 0) void'(img_q.pop_front());
      img_valid = (img_q.size() > 0);
      if (img_q.size() > 0) {img_last, img_byte} = img_q[0];
    end
  end

  task automatic send_rx(input bit pfx, input logic [DW-1:0] b, input int nbits);
    logic [DW:0] w;
    w = {pfx, b};
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); bclk = 1'b0; rx_line = w[DW-i];
      @(negedge clk); bclk = 1'b1;
    end
    @(negedge clk); bclk = 1'b0;
  endtask

  task automatic prime();
    @(negedge clk); bclk = 1'b1;
  endtask

  task automatic clock_bits(input int n, output logic [DW:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bclk = 1'b0;
      @(negedge clk); w[DW-i] = tx_line; bclk = 1'b1;
    end
  endtask

  task automatic tx_word(input logic [DW:0] exp, input string req);
    logic [DW:0] got;
    clock_bits(DW + 1, got);
    chk(got == exp, req, int'(got), int'(exp));
  endtask

  task automatic finish_word();
    @(negedge clk); bclk = 1'b0;
    @(negedge clk);
    chk(tx_line == 1'b1, "R6 line idle after word", int'(tx_line), 1);
  endtask

  task automatic pulse_irq(input bit expect_low);
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    for (int i = 0; i < IRQ + 2; i++) begin
      if (expect_low && i < IRQ)
        chk(tx_line == 1'b0, "R7 attention pulse low", int'(tx_line), 0);
      else if (expect_low)
        chk(tx_line == 1'b1, "R7 attention pulse ends", int'(tx_line), 1);
      else
        chk(tx_line == 1'b1, "R8 request ignored in frame", int'(tx_line), 1);
      @(negedge clk);
    end
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW:0] part;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R2 reset strobe", int'(cmd_valid), 0);
    chk(tx_line == 1'b1, "R6 reset line high", int'(tx_line), 1);
    chk(img_take == 1'b0, "R5 reset take", int'(img_take), 0);

    // Receive: commands and non-commands
    sel_n = 1'b0;
    send_rx(1'b0, 8'hA5, 9);
    send_rx(1'b0, 8'h3C, 9);
    send_rx(1'b1, 8'hFF, 9);
    @(negedge clk);
    chk(cmd_byte == 8'h3C, "R3 byte kept after non-command", int'(cmd_byte), 'h3C);
    send_rx(1'b0, 8'h00, 9);
    send_rx(1'b0, 8'h81, 9);

    // Receive abort and deselected bit clock
    send_rx(1'b0, 8'hC0, 4);
    sel_n = 1'b1; rx_line = 1'b0;
    repeat (12) begin @(negedge clk); bclk = ~bclk; end
    bclk = 1'b0;
    @(negedge clk);
    chk(cmd_seen == 4, "R10 no strobe while deselected", cmd_seen, 4);
    sel_n = 1'b0;
    send_rx(1'b0, 8'h5A, 9);
    @(negedge clk);
    chk(cmd_byte == 8'h5A, "R1 word after reselection", int'(cmd_byte), 'h5A);
    chk(cmd_seen == 5, "R1 R2 total commands", cmd_seen, 5);

    // Transmit: one frame of three bytes back to back
    rx_line = 1'b1;
    img_q.push_back({1'b0, 8'h12});
    img_q.push_back({1'b0, 8'hC3});
    img_q.push_back({1'b1, 8'h7E});
    repeat (2) @(negedge clk);
    prime();
    tx_word({1'b0, 8'h12}, "R4 first byte");
    tx_word({1'b0, 8'hC3}, "R5 middle byte flag");
    tx_word({1'b1, 8'h7E}, "R5 last byte flag");
    finish_word();
    chk(img_q.size() == 0, "R5 all bytes taken", img_q.size(), 0);

    // Attention pulse between frames
    pulse_irq(1'b1);

    // Open frame blocks the attention pulse
    img_q.push_back({1'b0, 8'h44});
    repeat (2) @(negedge clk);
    prime();
    tx_word({1'b0, 8'h44}, "R4 open frame byte");
    finish_word();
    pulse_irq(1'b0);
    img_q.push_back({1'b1, 8'h99});
    repeat (2) @(negedge clk);
    prime();
    tx_word({1'b1, 8'h99}, "R5 closing byte");
    finish_word();
    pulse_irq(1'b1);

    // Abort mid-word, then restart
    img_q.push_back({1'b0, 8'h0F});
    img_q.push_back({1'b1, 8'hA6});
    repeat (2) @(negedge clk);
    prime();
    clock_bits(4, part);
    chk(part[DW:DW-3] == 4'b0000, "R4 partial bits", int'(part[DW:DW-3]), 0);
    sel_n = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b1, "R9 line high after abort", int'(tx_line), 1);
    @(negedge clk);
    sel_n = 1'b0;
    prime();
    tx_word({1'b1, 8'hA6}, "R9 restart from prefix");
    finish_word();

    repeat (4) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule